// File: doc/BRIEF.md
# Multi-interface ingress port tagger

This block takes in packet words from up to four independent link interfaces of the POS-PHY (SPI-3) kind. Each interface presents a word strobe, a data word, a parity bit, a local port number and an end-of-packet marker. For every interface, the block checks the parity of each word against a selectable sense. It groups the words into bursts of a fixed maximum length. It then forwards each word to that interface's buffer write port, together with an outgoing port tag.

The tag is built without any control input. The local port number sits in the low bits. The index of the source interface sits directly above it, in at most two bits. This keeps two ports that share a number on different interfaces apart once their traffic is merged downstream. The tag is captured at the first word of a burst and held for the rest of that burst.

For each interface, the block tracks how full the buffer is. It counts accepted writes and downstream reads. It raises a full flag either at full capacity or at three-quarters of capacity plus one entry. A word that arrives while the buffer is at capacity is not written. A parity mismatch sets a sticky error bit for that interface. Software clears the bit by writing 1 to it.

Top module: `ingress_tagger`

## Requirements
- R1: For every word written on interface i with local port p, the tag written with it equals (i shifted left by the port-field width) OR p. With 4 interfaces of 4 ports each, tag[1:0] is the port and tag[3:2] is the interface. The written word appears on that interface's write outputs one clock after it was presented.
- R2: The tag is taken from the port input at the first word of a burst. The port input has no effect on the tag for the remaining words of that burst.
- R3: A burst ends on a word with end-of-packet set, or on the word that brings the burst count to BURST_LEN. The write-last output is 1 exactly on that word. The next word opens a new burst and takes a new tag.
- R4: When the parity-sense input is 1 (odd), a word is in error when the total number of ones in the data word and its parity bit is even. When the input is 0 (even), a word is in error when that total is odd.
- R5: A parity error sets that interface's error bit and no other. The bit stays set until a 1 is written to that interface's clear input. If a new error and a clear arrive in the same cycle, the error wins.
- R6: The occupancy of each buffer rises by one for each accepted write and falls by one for each read strobe while the occupancy is nonzero. A read strobe while the buffer is empty has no effect.
- R7: When the threshold-select input is 0, the full flag is 1 exactly when the occupancy equals BUF_DEPTH. A word presented while the occupancy equals BUF_DEPTH is not written: its write-enable stays 0.
- R8: When the threshold-select input is 1, the full flag is 1 exactly when the occupancy is at least 3*BUF_DEPTH/4+1.
- R9: While reset is held, and in the first cycle after it, every write-enable, write-last, full flag and error bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| full_sel | input | 1 | Full threshold: 0 capacity, 1 three-quarters plus one |
| in_valid | input | NUM_IF | Word strobe, one bit per interface |
| in_data | input | NUM_IF*DATA_W | Data words, interface i in slice i |
| in_par | input | NUM_IF | Parity bit per interface |
| in_port | input | NUM_IF*PW | Local port number per interface |
| in_eop | input | NUM_IF | End-of-packet marker per interface |
| rd_en | input | NUM_IF | Downstream read strobe per buffer |
| err_clr | input | NUM_IF | Write-1-to-clear for the error bits |
| wr_en | output | NUM_IF | Buffer write enable per interface |
| wr_data | output | NUM_IF*DATA_W | Buffer write data |
| wr_tag | output | NUM_IF*TW | Outgoing port tag, TW = PW + interface-index width |
| wr_last | output | NUM_IF | Last word of a burst |
| buf_full | output | NUM_IF | Buffer full flag |
| par_err | output | NUM_IF | Sticky parity error bits |

## Verification
The hardest case to reach from the ports is the length-limited end of a burst. It needs BURST_LEN back-to-back words with no end-of-packet, and the buffer must not fill and drop words along the way. The stimulus therefore holds that buffer's read strobe high, so the occupancy stays at one. It changes the port input on every word to show that the held tag is unaffected. A second hard case is a read strobe on an empty buffer. It can only be seen indirectly. The bench drains a buffer, keeps strobing reads, and then counts writes up to the three-quarters threshold. A wrapped counter would show up there as dropped writes or an early full flag.

// File: rtl/ingress_tagger_pkg.sv
package ingress_tagger_pkg;
  // width of the local port field; a single port still takes one bit
  function automatic int port_w(input int ports);
    return (ports > 1) ? $clog2(ports) : 1;
  endfunction

  // width of the interface index field; absent for one interface
  function automatic int idx_w(input int n_if);
    return (n_if > 1) ? $clog2(n_if) : 0;
  endfunction

  function automatic int tag_w(input int n_if, input int ports);
    return port_w(ports) + idx_w(n_if);
  endfunction
endpackage

// File: rtl/itg_parity.sv
module itg_parity #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              odd,
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  input  logic              clr,
  output logic              err
);
  logic bad;

  always_comb bad = vld && ((^{data, par}) != odd);

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= bad | (err & ~clr);
  end
endmodule

// File: rtl/itg_fill.sv
module itg_fill #(
  parameter int DEPTH = 16,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hi_sel,
  input  logic          wr,
  input  logic          rd,
  output logic          accept,
  output logic [FW-1:0] fill,
  output logic          full
);
  localparam logic [FW-1:0] CAP    = FW'(DEPTH);
  localparam logic [FW-1:0] THR_HI = FW'((3 * DEPTH) / 4 + 1);

  logic          do_wr, do_rd;
  logic [FW-1:0] fill_d, thr;

  always_comb begin
    accept = (fill < CAP);
    do_wr  = wr && accept;
    do_rd  = rd && (fill != '0);
    fill_d = fill;
    if (do_wr && !do_rd)      fill_d = fill + 1'b1;
    else if (do_rd && !do_wr) fill_d = fill - 1'b1;
    thr = hi_sel ? THR_HI : CAP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      full <= 1'b0;
    end else begin
      fill <= fill_d;
      full <= (fill_d >= thr);
    end
  end
endmodule

// File: rtl/itg_burst.sv
module itg_burst #(
  parameter int DATA_W    = 8,
  parameter int PW        = 2,
  parameter int IW        = 2,
  parameter int IDX       = 0,
  parameter int BURST_LEN = 32,
  parameter int TW        = PW + IW,
  parameter int CW        = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  input  logic [PW-1:0]     port,
  input  logic              eop,
  input  logic              accept,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [TW-1:0]     wr_tag,
  output logic              wr_last
);
  localparam logic [CW-1:0] LEN = CW'(BURST_LEN);

  logic          in_burst;
  logic [CW-1:0] cnt, cnt_nx;
  logic [TW-1:0] tag_q, tag_new, cur_tag;
  logic          last;

  generate
    if (IW > 0) begin : g_idx
      localparam logic [IW-1:0] IDX_V = IW'(IDX);
      assign tag_new = {IDX_V, port};
    end else begin : g_noidx
      assign tag_new = port;
    end
  endgenerate

  always_comb begin
    cnt_nx  = in_burst ? cnt + 1'b1 : CW'(1);
    last    = eop || (cnt_nx == LEN);
    cur_tag = in_burst ? tag_q : tag_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst <= 1'b0;
      cnt      <= '0;
      tag_q    <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      wr_tag   <= '0;
      wr_last  <= 1'b0;
    end else begin
      wr_en   <= vld && accept;
      wr_last <= vld && accept && last;
      if (vld) begin
        wr_data  <= data;
        wr_tag   <= cur_tag;
        tag_q    <= cur_tag;
        cnt      <= last ? '0 : cnt_nx;
        in_burst <= !last;
      end
    end
  end
endmodule

// File: rtl/ingress_tagger.sv
module ingress_tagger
  import ingress_tagger_pkg::*;
#(
  parameter int NUM_IF    = 4,
  parameter int PORTS     = 4,
  parameter int BURST_LEN = 32,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 64
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  par_odd,
  input  logic                                  full_sel,
  input  logic [NUM_IF-1:0]                     in_valid,
  input  logic [NUM_IF*DATA_W-1:0]              in_data,
  input  logic [NUM_IF-1:0]                     in_par,
  input  logic [NUM_IF*port_w(PORTS)-1:0]       in_port,
  input  logic [NUM_IF-1:0]                     in_eop,
  input  logic [NUM_IF-1:0]                     rd_en,
  input  logic [NUM_IF-1:0]                     err_clr,
  output logic [NUM_IF-1:0]                     wr_en,
  output logic [NUM_IF*DATA_W-1:0]              wr_data,
  output logic [NUM_IF*tag_w(NUM_IF,PORTS)-1:0] wr_tag,
  output logic [NUM_IF-1:0]                     wr_last,
  output logic [NUM_IF-1:0]                     buf_full,
  output logic [NUM_IF-1:0]                     par_err
);
  localparam int PW = port_w(PORTS);
  localparam int IW = idx_w(NUM_IF);
  localparam int TW = PW + IW;
  localparam int FW = $clog2(BUF_DEPTH + 1);

  logic [NUM_IF*FW-1:0] fill_lvl;
  logic [NUM_IF-1:0]    accept;

  generate
    for (genvar i = 0; i < NUM_IF; i++) begin : g_if
      itg_parity #(.DATA_W(DATA_W)) u_par (
        .clk  (clk),
        .rst  (rst),
        .odd  (par_odd),
        .vld  (in_valid[i]),
        .data (in_data[i*DATA_W +: DATA_W]),
        .par  (in_par[i]),
        .clr  (err_clr[i]),
        .err  (par_err[i])
      );

      itg_fill #(.DEPTH(BUF_DEPTH), .FW(FW)) u_fill (
        .clk    (clk),
        .rst    (rst),
        .hi_sel (full_sel),
        .wr     (in_valid[i]),
        .rd     (rd_en[i]),
        .accept (accept[i]),
        .fill   (fill_lvl[i*FW +: FW]),
        .full   (buf_full[i])
      );

      itg_burst #(
        .DATA_W(DATA_W), .PW(PW), .IW(IW), .IDX(i), .BURST_LEN(BURST_LEN)
      ) u_burst (
        .clk     (clk),
        .rst     (rst),
        .vld     (in_valid[i]),
        .data    (in_data[i*DATA_W +: DATA_W]),
        .port    (in_port[i*PW +: PW]),
        .eop     (in_eop[i]),
        .accept  (accept[i]),
        .wr_en   (wr_en[i]),
        .wr_data (wr_data[i*DATA_W +: DATA_W]),
        .wr_tag  (wr_tag[i*TW +: TW]),
        .wr_last (wr_last[i])
      );
    end
  endgenerate
endmodule

// File: rtl/itg_checker.sv
module itg_checker #(
  parameter int NUM_IF    = 4,
  parameter int PW        = 2,
  parameter int IW        = 2,
  parameter int TW        = 4,
  parameter int FW        = 7,
  parameter int BUF_DEPTH = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 full_sel,
  input logic [NUM_IF-1:0]    wr_en,
  input logic [NUM_IF-1:0]    wr_last,
  input logic [NUM_IF*TW-1:0] wr_tag,
  input logic [NUM_IF-1:0]    buf_full,
  input logic [NUM_IF-1:0]    par_err,
  input logic [NUM_IF-1:0]    err_clr,
  input logic [NUM_IF*FW-1:0] fill_lvl
);
  generate
    for (genvar i = 0; i < NUM_IF; i++) begin : g_chk
      AST_LAST_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_last[i] |-> wr_en[i]);  // R3

      AST_TAG_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en[i] && !wr_last[i]) && wr_en[i]) |-> $stable(wr_tag[i*TW +: TW]));  // R2

      AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_lvl[i*FW +: FW] <= FW'(BUF_DEPTH));  // R6

      AST_NO_WRITE_AT_CAP: assert property (@(posedge clk) disable iff (rst)
        wr_en[i] |-> ($past(fill_lvl[i*FW +: FW]) < FW'(BUF_DEPTH)));  // R7

      AST_FULL_AT_CAP: assert property (@(posedge clk) disable iff (rst)
        (!full_sel && $past(!full_sel) && fill_lvl[i*FW +: FW] == FW'(BUF_DEPTH)) |-> buf_full[i]);  // R7

      AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(par_err[i]) && !$past(err_clr[i])) |-> par_err[i]);  // R5

      if (IW > 0) begin : g_idx
        AST_TAG_INDEX: assert property (@(posedge clk) disable iff (rst)
          wr_en[i] |-> (wr_tag[i*TW + PW +: IW] == IW'(i)));  // R1
      end
    end
  endgenerate
endmodule

bind ingress_tagger itg_checker #(
  .NUM_IF(NUM_IF), .PW(PW), .IW(IW), .TW(TW), .FW(FW), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .full_sel (full_sel),
  .wr_en    (wr_en),
  .wr_last  (wr_last),
  .wr_tag   (wr_tag),
  .buf_full (buf_full),
  .par_err  (par_err),
  .err_clr  (err_clr),
  .fill_lvl (fill_lvl)
);

// File: tb/ingress_tagger_test.sv
`timescale 1ns/1ps
module ingress_tagger_test;
  localparam int NI = 4, NP = 4, BL = 32, DW = 8, DEP = 16, PW = 2, TW = 4;
  localparam int THR = (3 * DEP) / 4 + 1;

  logic clk = 1'b0, rst = 1'b1, par_odd = 1'b0, full_sel = 1'b0;
  logic [NI-1:0]    in_valid = '0, in_par = '0, in_eop = '0, rd_en = '0, err_clr = '0;
  logic [NI*DW-1:0] in_data = '0;
  logic [NI*PW-1:0] in_port = '0;
  logic [NI-1:0]    wr_en, wr_last, buf_full, par_err;
  logic [NI*DW-1:0] wr_data;
  logic [NI*TW-1:0] wr_tag;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ingress_tagger #(.NUM_IF(NI), .PORTS(NP), .BURST_LEN(BL), .DATA_W(DW), .BUF_DEPTH(DEP)) uut (
    .clk(clk), .rst(rst), .par_odd(par_odd), .full_sel(full_sel),
    .in_valid(in_valid), .in_data(in_data), .in_par(in_par), .in_port(in_port),
    .in_eop(in_eop), .rd_en(rd_en), .err_clr(err_clr),
    .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag), .wr_last(wr_last),
    .buf_full(buf_full), .par_err(par_err));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic good_par(input logic [DW-1:0] d, input logic odd);
    return odd ? ~^d : ^d;
  endfunction

  // present one word at a falling edge, return at the next falling edge
  task automatic send(input int i, input logic [DW-1:0] d, input logic p,
                      input int port, input logic e);
    in_valid[i] = 1'b1;
    in_data[i*DW +: DW] = d;
    in_par[i] = p;
    in_port[i*PW +: PW] = PW'(port);
    in_eop[i] = e;
    @(negedge clk);
    in_valid[i] = 1'b0;
    in_eop[i] = 1'b0;
  endtask

  task automatic drain();
    rd_en = '1;
    repeat (DEP + 4) @(negedge clk);
    rd_en = '0;
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 wr_en", wr_en, 0);
    chk("R9 full", buf_full, 0);
    chk("R9 err", par_err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after release", {wr_en, wr_last, buf_full, par_err}, 0);

    // R1: every interface and port
    for (int i = 0; i < NI; i++) begin
      for (int p = 0; p < NP; p++) begin
        send(i, DW'(i * 16 + p), good_par(DW'(i * 16 + p), 1'b0), p, 1'b1);
        chk("R1 wr_en", wr_en, 1 << i);
        chk("R1 tag", wr_tag[i*TW +: TW], i * NP + p);
        chk("R1 data", wr_data[i*DW +: DW], i * 16 + p);
        chk("R3 eop last", wr_last[i], 1);
      end
    end
    drain();

    // R2/R3: short burst ended by end-of-packet, port changing
    rd_en[2] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      send(2, DW'(k), good_par(DW'(k), 1'b0), (1 + k) % NP, k == 4);
      chk("R2 held tag", wr_tag[2*TW +: TW], 2 * NP + 1);
      chk("R3 last eop", wr_last[2], (k == 4) ? 1 : 0);
    end
    // R3: burst ended by length
    for (int k = 0; k < BL; k++) begin
      send(2, DW'(k), good_par(DW'(k), 1'b0), (3 + k) % NP, 1'b0);
      chk("R2 held tag long", wr_tag[2*TW +: TW], 2 * NP + 3);
      chk("R3 last length", wr_last[2], (k == BL - 1) ? 1 : 0);
    end
    send(2, 8'h11, good_par(8'h11, 1'b0), 0, 1'b0);
    chk("R3 new burst tag", wr_tag[2*TW +: TW], 2 * NP + 0);
    chk("R3 new burst last", wr_last[2], 0);
    send(2, 8'h12, good_par(8'h12, 1'b0), 1, 1'b1);
    rd_en[2] = 1'b0;

    // R4/R5: parity sense on interface 0
    rd_en[0] = 1'b1;
    for (int s = 0; s < 2; s++) begin
      par_odd = s[0];
      for (int v = 0; v < 8; v++) begin
        logic [DW-1:0] d;
        d = DW'(v * 37 + s * 5);
        send(0, d, good_par(d, par_odd), 0, 1'b1);
        chk("R4 good word", par_err[0], 0);
        send(0, d, ~good_par(d, par_odd), 0, 1'b1);
        chk("R4 bad word", par_err, 1);
        send(0, d, good_par(d, par_odd), 0, 1'b1);
        chk("R5 sticky", par_err[0], 1);
        err_clr[0] = 1'b1;
        @(negedge clk);
        err_clr[0] = 1'b0;
        chk("R5 clear", par_err[0], 0);
      end
    end
    // R5: error beats clear in the same cycle
    err_clr[0] = 1'b1;
    send(0, 8'h01, ~good_par(8'h01, par_odd), 0, 1'b1);
    err_clr[0] = 1'b0;
    chk("R5 set wins", par_err[0], 1);
    // R5: error on interface 3 alone
    err_clr[0] = 1'b1;
    @(negedge clk);
    err_clr[0] = 1'b0;
    send(3, 8'h03, ~good_par(8'h03, par_odd), 0, 1'b1);
    chk("R5 isolated", par_err, 8);
    err_clr[3] = 1'b1;
    @(negedge clk);
    err_clr[3] = 1'b0;
    rd_en[0] = 1'b0;
    drain();

    // R7: capacity threshold on interface 3
    full_sel = 1'b0;
    @(negedge clk);
    for (int k = 0; k < DEP; k++) begin
      send(3, DW'(k), good_par(DW'(k), par_odd), 2, 1'b0);
      chk("R7 write accepted", wr_en[3], 1);
      chk("R7 full flag", buf_full[3], (k == DEP - 1) ? 1 : 0);
    end
    send(3, 8'hAA, good_par(8'hAA, par_odd), 2, 1'b1);
    chk("R7 dropped at cap", wr_en[3], 0);
    chk("R7 still full", buf_full[3], 1);
    rd_en[3] = 1'b1;
    @(negedge clk);
    rd_en[3] = 1'b0;
    chk("R6 read lowers fill", buf_full[3], 0);
    send(3, 8'hAB, good_par(8'hAB, par_odd), 2, 1'b1);
    chk("R6 refill to cap", buf_full[3], 1);
    drain();

    // R6: extra reads on an empty buffer, then R8 threshold
    rd_en[3] = 1'b1;
    repeat (5) @(negedge clk);
    rd_en[3] = 1'b0;
    full_sel = 1'b1;
    @(negedge clk);
    chk("R8 empty not full", buf_full[3], 0);
    for (int k = 0; k < THR; k++) begin
      send(3, DW'(k), good_par(DW'(k), par_odd), 1, 1'b0);
      chk("R6 write after empty reads", wr_en[3], 1);
      chk("R8 full flag", buf_full[3], (k == THR - 1) ? 1 : 0);
    end
    send(3, 8'h55, good_par(8'h55, par_odd), 1, 1'b1);
    chk("R8 above threshold", buf_full[3], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule